// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single line. The line rests high. A frame begins with one low start bit. The data bits follow, least significant first. An optional extra bit, taken from its own input, comes next. An optional parity bit follows that. The frame closes with a high stop period. Every bit lasts sixteen ticks of an externally supplied baud tick, which runs at sixteen times the bit rate.

A small set of mode inputs sets the frame shape:
- the number of data bits (five to eight);
- whether parity is present, and which of four kinds it is;
- whether the extra bit is present;
- whether the stop period is short or long.

The block captures the mode, the data word and the extra-bit value when it accepts a start strobe. Changes on those inputs during a frame have no effect on that frame. A busy flag covers the whole frame. A one-cycle done pulse marks its end, and a new frame can start on the next accepted strobe.

Top module: `sfx_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd_o` is 1, `busy_o` is 0 and `done_o` is 0. Baud ticks while idle do not change this.
- R2: A `start_i` high while `busy_o` is 0 is accepted on that clock edge. `busy_o` is 1 from the next cycle, and the line then drives a 0 start bit.
- R3: `len_sel_i` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The data bits follow the start bit, bit 0 of `data_i` first.
- R4: When `extra_en_i` is 1, one bit equal to `extra_i` is sent directly after the last data bit. When it is 0, no such bit is sent.
- R5: When `par_en_i` is 1, one parity bit is sent after the data and the extra bit (if present). `par_kind_i` selects the parity bit's value:
  - 0 (odd): it makes the count of ones among the sent data bits plus the parity bit odd.
  - 1 (even): it makes that count even.
  - 2 (mark): it is always 1.
  - 3 (space): it is always 0.
- R6: When `par_en_i` is 0, no parity bit is sent, and the stop period follows the data (or the extra bit) at once.
- R7: The stop period holds the line high. With `long_stop_i` at 0 it lasts 16 ticks. With `long_stop_i` at 1 it lasts 32 ticks for 6, 7 or 8 data bits, and 24 ticks for 5 data bits.
- R8: `done_o` is high for exactly one clock cycle, in the first cycle after the last stop tick. `busy_o` is 0 in that same cycle.
- R9: A `start_i` seen while `busy_o` is 1 is ignored. Changes to data, extra-bit or mode inputs during a frame do not alter that frame.
- R10: Each start, data, extra and parity bit is held on the line for exactly 16 baud ticks. The line changes only in a cycle that follows a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick_i | input | 1 | One-cycle tick at 16x bit rate |
| start_i | input | 1 | Start strobe, accepted when idle |
| data_i | input | 8 | Data word, bit 0 sent first |
| extra_i | input | 1 | Value of the optional extra bit |
| len_sel_i | input | 2 | Data length code (5 + code bits) |
| par_kind_i | input | 2 | Parity kind: odd, even, mark, space |
| par_en_i | input | 1 | Parity bit present |
| extra_en_i | input | 1 | Extra bit present |
| long_stop_i | input | 1 | Long stop period |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that `baud_tick_i` is a single-cycle pulse that arrives no more often than every other clock. They also assume that `start_i` may be raised at any time, including while a frame runs. The stimulus produces the tick from a free-running divide-by-three counter, so that assumption always holds. Random strobes and random mode and data changes are injected mid-frame, only while `busy_o` is high, to exercise the ignore path without ever starting a frame the bench does not expect.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

   // Widest data field the frame format allows.
   localparam int unsigned MAX_DATA = 8;
   // Start bit + data + extra bit + parity bit.
   localparam int unsigned FRAME_W  = 1 + MAX_DATA + 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BITS = 2'd1,
      ST_STOP = 2'd2
   } tx_state_e;

   typedef enum logic [1:0] {
      PK_ODD   = 2'd0,
      PK_EVEN  = 2'd1,
      PK_MARK  = 2'd2,
      PK_SPACE = 2'd3
   } par_kind_e;

endpackage

// File: rtl/sfx_frame_build.sv
// Combinational frame composer: turns the word and mode into a bit vector
// (LSB leaves first), the number of timed bits and the stop length in ticks.
module sfx_frame_build #(
   parameter int unsigned OVS = 16,
   parameter int unsigned FW  = sfx_pkg::FRAME_W,
   parameter int unsigned NW  = $clog2(FW + 1),
   parameter int unsigned SW  = $clog2(2 * OVS + 1)
) (
   input  logic [7:0]    data,
   input  logic          extra,
   input  logic [1:0]    len_sel,
   input  logic [1:0]    par_kind,
   input  logic          par_en,
   input  logic          extra_en,
   input  logic          long_stop,
   output logic [FW-1:0] frame,
   output logic [NW-1:0] nbits,
   output logic [SW-1:0] stop_ticks
);
   import sfx_pkg::*;

   localparam int unsigned DW = MAX_DATA;

   logic [NW-1:0] dcnt;
   logic [DW-1:0] masked;
   logic          par_bit;

   assign dcnt = NW'(5) + NW'(len_sel);

   // Keep only the data bits that belong to the selected length.
   for (genvar j = 0; j < DW; j++) begin : g_mask
      assign masked[j] = data[j] & (dcnt > NW'(j));
   end

   always_comb begin
      unique case (par_kind_e'(par_kind))
         PK_ODD:   par_bit = ~(^masked);
         PK_EVEN:  par_bit = ^masked;
         PK_MARK:  par_bit = 1'b1;
         default:  par_bit = 1'b0;
      endcase
   end

   always_comb begin
      logic [NW-1:0] pos;
      frame    = '1;
      frame[0] = 1'b0;
      for (int k = 0; k < DW; k++) begin
         if (NW'(k) < dcnt) frame[k + 1] = data[k];
      end
      pos = dcnt + NW'(1);
      if (extra_en) begin
         frame[pos] = extra;
         pos        = pos + NW'(1);
      end
      if (par_en) begin
         frame[pos] = par_bit;
         pos        = pos + NW'(1);
      end
      nbits = pos;
   end

   always_comb begin
      if (!long_stop)        stop_ticks = SW'(OVS);
      else if (len_sel == 0) stop_ticks = SW'(OVS + OVS / 2);
      else                   stop_ticks = SW'(2 * OVS);
   end

endmodule

// File: rtl/sfx_tick_timer.sv
// Counts baud ticks up to a limit; expire marks the tick that ends the period.
module sfx_tick_timer #(
   parameter int unsigned TW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [TW-1:0] lim,
   output logic          expire
);
   logic [TW-1:0] cnt;

   assign expire = tick && (cnt == lim - TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (clr || expire)  cnt <= '0;
      else if (tick)           cnt <= cnt + TW'(1);
   end

endmodule

// File: rtl/sfx_tx.sv
module sfx_tx #(
   parameter int unsigned OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick_i,
   input  logic       start_i,
   input  logic [7:0] data_i,
   input  logic       extra_i,
   input  logic [1:0] len_sel_i,
   input  logic [1:0] par_kind_i,
   input  logic       par_en_i,
   input  logic       extra_en_i,
   input  logic       long_stop_i,
   output logic       txd_o,
   output logic       busy_o,
   output logic       done_o
);
   import sfx_pkg::*;

   localparam int unsigned FW = FRAME_W;
   localparam int unsigned NW = $clog2(FW + 1);
   localparam int unsigned SW = $clog2(2 * OVS + 1);

   // A 1.5-bit stop period needs an even oversampling ratio.
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("sfx_tx: OVS must be even and at least 4");
   end

   tx_state_e     state;
   logic [FW-1:0] shreg;
   logic [NW-1:0] left;
   logic [SW-1:0] stop_q;
   logic          done_q;

   logic [FW-1:0] frame_w;
   logic [NW-1:0] nbits_w;
   logic [SW-1:0] stop_w;
   logic          accept;
   logic          expire;
   logic [SW-1:0] lim;

   assign accept = start_i && (state == ST_IDLE);
   assign lim    = (state == ST_STOP) ? stop_q : SW'(OVS);

   sfx_frame_build #(
      .OVS (OVS),
      .FW  (FW),
      .NW  (NW),
      .SW  (SW)
   ) build_i (
      .data       (data_i),
      .extra      (extra_i),
      .len_sel    (len_sel_i),
      .par_kind   (par_kind_i),
      .par_en     (par_en_i),
      .extra_en   (extra_en_i),
      .long_stop  (long_stop_i),
      .frame      (frame_w),
      .nbits      (nbits_w),
      .stop_ticks (stop_w)
   );

   sfx_tick_timer #(
      .TW (SW)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .tick   (baud_tick_i),
      .lim    (lim),
      .expire (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         shreg  <= '1;
         left   <= '0;
         stop_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  shreg  <= frame_w;
                  left   <= nbits_w;
                  stop_q <= stop_w;
                  state  <= ST_BITS;
               end
            end
            ST_BITS: begin
               if (expire) begin
                  shreg <= {1'b1, shreg[FW-1:1]};
                  left  <= left - NW'(1);
                  if (left == NW'(1)) state <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (expire) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign txd_o  = (state == ST_BITS) ? shreg[0] : 1'b1;
   assign busy_o = (state != ST_IDLE);
   assign done_o = done_q;

endmodule

// File: rtl/sfx_tx_chk.sv
module sfx_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick_i,
   input logic start_i,
   input logic txd_o,
   input logic busy_o,
   input logic done_o
);

   a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> txd_o);

   a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (!busy_o && $past(busy_o)));

   a_r10_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && !$past(baud_tick_i)) |-> $stable(txd_o));

endmodule

bind sfx_tx sfx_tx_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .baud_tick_i (baud_tick_i),
   .start_i     (start_i),
   .txd_o       (txd_o),
   .busy_o      (busy_o),
   .done_o      (done_o)
);

// File: tb/sfx_tx_tb_top.sv
module sfx_tx_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] data_i = '0;
   logic       extra_i = 1'b0;
   logic [1:0] len_sel_i = '0;
   logic [1:0] par_kind_i = '0;
   logic       par_en_i = 1'b0;
   logic       extra_en_i = 1'b0;
   logic       long_stop_i = 1'b0;
   logic       txd_o, busy_o, done_o;
   logic [1:0] div;
   logic       baud_tick;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   always_ff @(posedge clk) begin
      if (!rst_n)         div <= '0;
      else if (div == 2)  div <= '0;
      else                div <= div + 2'd1;
   end
   assign baud_tick = rst_n && (div == 2'd0);

   sfx_tx dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .baud_tick_i (baud_tick),
      .start_i     (start_i),
      .data_i      (data_i),
      .extra_i     (extra_i),
      .len_sel_i   (len_sel_i),
      .par_kind_i  (par_kind_i),
      .par_en_i    (par_en_i),
      .extra_en_i  (extra_en_i),
      .long_stop_i (long_stop_i),
      .txd_o       (txd_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected frame from the requirements.
   task automatic build_exp(input logic [7:0] d, input logic x, input logic [1:0] l,
                            input logic [1:0] pk, input logic pe, input logic xe,
                            input logic ls, output logic [15:0] fr, output int nb,
                            output int st);
      int n;
      int pos;
      logic ones;
      n = 5 + int'(l);
      fr = '1;
      fr[0] = 1'b0;
      pos = 1;
      ones = 1'b0;
      for (int i = 0; i < n; i++) begin
         fr[pos] = d[i];
         ones ^= d[i];
         pos++;
      end
      if (xe) begin
         fr[pos] = x;
         pos++;
      end
      if (pe) begin
         case (pk)
            2'd0: fr[pos] = ~ones;
            2'd1: fr[pos] = ones;
            2'd2: fr[pos] = 1'b1;
            default: fr[pos] = 1'b0;
         endcase
         pos++;
      end
      nb = pos;
      st = !ls ? 16 : ((n == 5) ? 24 : 32);
   endtask

   task automatic run_frame(input logic [7:0] d, input logic x, input logic [1:0] l,
                            input logic [1:0] pk, input logic pe, input logic xe,
                            input logic ls, input bit noise);
      logic [15:0] fr;
      int nb, st, total, t, last, n, bad;
      build_exp(d, x, l, pk, pe, xe, ls, fr, nb, st);
      n = 5 + int'(l);
      total = nb * 16 + st;
      @(negedge clk);
      data_i = d; extra_i = x; len_sel_i = l; par_kind_i = pk;
      par_en_i = pe; extra_en_i = xe; long_stop_i = ls; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R2 busy after accept", int'(busy_o), 1);
      t = 0;
      last = -1;
      bad = 0;
      while (t < total) begin
         if (t != last) begin
            last = t;
            if (t < nb * 16) begin
               int idx, ph;
               string tag;
               idx = t / 16;
               ph = t % 16;
               if (idx == 0)                    tag = "R2 start bit";
               else if (idx <= n)               tag = "R3 data bit";
               else if (xe && idx == n + 1)     tag = "R4 extra bit";
               else                             tag = "R5 parity bit";
               if (ph == 8) begin
                  chk(txd_o == fr[idx], tag, int'(txd_o), int'(fr[idx]));
                  if (txd_o != fr[idx]) bad++;
               end else if (ph == 1 || ph == 15) begin
                  chk(txd_o == fr[idx], "R10 bit held 16 ticks", int'(txd_o), int'(fr[idx]));
               end
            end else if (t == nb * 16 + 8 || t == total - 1) begin
               chk(txd_o && busy_o && !done_o, "R7 stop period high and busy",
                   int'({txd_o, busy_o, done_o}), 6);
               if (!txd_o) bad++;
            end
         end
         start_i = 1'b0;
         if (noise && t < total - 1 && ($urandom % 12) == 0) begin
            start_i = 1'b1;
            data_i = 8'($urandom);
            extra_i = 1'($urandom);
            len_sel_i = 2'($urandom);
            par_kind_i = 2'($urandom);
            par_en_i = 1'($urandom);
            extra_en_i = 1'($urandom);
            long_stop_i = 1'($urandom);
         end
         if (baud_tick) t++;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(done_o == 1'b1, "R8 done at frame end (R6/R7 length)", int'(done_o), 1);
      chk(busy_o == 1'b0, "R8 busy low with done", int'(busy_o), 0);
      if (done_o != 1'b1) bad++;
      if (noise) chk(bad == 0, "R9 frame unaffected by ignored inputs", bad, 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R8 done lasts one cycle", int'(done_o), 0);
      chk(txd_o == 1'b1 && busy_o == 1'b0, "R1 idle after frame",
          int'({txd_o, busy_o}), 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd_o == 1'b1, "R1 reset line high", int'(txd_o), 1);
      chk(busy_o == 1'b0, "R1 reset not busy", int'(busy_o), 0);
      chk(done_o == 1'b0, "R1 reset no done", int'(done_o), 0);
      repeat (40) @(negedge clk);
      chk(txd_o == 1'b1 && !busy_o, "R1 idle ticks leave line high",
          int'({txd_o, busy_o}), 2);

      // Directed corners.
      run_frame(8'hA5, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0); // R7 5-bit long: 24
      run_frame(8'h3C, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0); // R7 8-bit long: 32
      run_frame(8'h15, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); // R6 no parity, short
      run_frame(8'h00, 1'b0, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); // R5 odd on zeros
      run_frame(8'h81, 1'b0, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0); // R5 even, bit7 masked
      run_frame(8'h00, 1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0); // R4 + R5 mark
      run_frame(8'hFF, 1'b0, 2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0); // R4 + R5 space
      run_frame(8'h5A, 1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1); // R9 noisy

      for (int k = 0; k < 24; k++) begin
         run_frame(8'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), bit'(k % 2));
         repeat ($urandom % 5) @(negedge clk);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule